// File: doc/BRIEF.md
# Serial Block-Protocol Configuration Slave

This block is a two-wire serial slave that answers at a single fixed 7-bit device address and holds a small bank of configuration bytes. The bank's top two bytes drive twelve output-pair enable lines and one enhanced-drive select. A host writes the bank with a block write. After the address byte the host sends a command byte and a length byte, which the slave acknowledges and discards, and then the data bytes. A block read returns a fixed length byte first and then the bank contents.

Access is always sequential and always starts at bank byte 0. There is no random addressing. The clock and data lines are sampled through synchronizers against a much faster system clock. Data is driven open-drain: the slave either pulls the line low or releases it. Start and stop conditions abort whatever frame is in progress.

Top module: `cfg_blk_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (device 0x69, write) and 0xD3 (device 0x69, read). Any other address byte gets no acknowledge, and the slave then ignores the bus, acknowledging nothing, until the next start.
- R2: In a write, the slave acknowledges the two bytes after the address and ignores their values. Each later data byte is stored in bank bytes 0, 1, 2 and onward, in that order. A byte takes effect on the SCL falling edge that ends its eighth bit.
- R3: Every data byte of a write is acknowledged, including bytes past the last bank byte (byte 7). Those extra bytes are discarded.
- R4: A read returns the length value 0x09 first, then bank bytes 0 to 7 in ascending order, then 0xFF for every further byte. Bits are sent MSB first.
- R5: A missing master acknowledge after a read byte ends the transfer. The slave releases SDA and drives nothing until the next start.
- R6: pair_en[7:0] equals bank byte 7 and pair_en[11:8] equals bank byte 6 bits 3..0. After reset all twelve bits are 1.
- R7: drive_boost equals bank byte 6 bit 5 and resets to 0. Byte 6 bits 7, 6 and 4 always read back 0 and ignore writes.
- R8: A start or stop arriving in the middle of a byte aborts the frame without storing the partial byte. A new start always begins at the address phase and at bank byte 0.
- R9: The slave changes SDA only while SCL is low. The one exception is releasing SDA on a start or stop.
- R10: After reset SDA is released, bytes 0..5 are 0x00, byte 6 is 0x0F and byte 7 is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND bus value) |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| pair_en | output | 12 | Output-pair enables, 1 = enabled |
| drive_boost | output | 1 | Enhanced output drive select |

## Verification
Every SCL edge reaches the control logic three system clocks after the pin changes: two synchronizer stages plus one edge-detect register. A written byte therefore appears on pair_en and drive_boost exactly three clocks after the SCL fall that ends its eighth bit. The bench's reference model schedules each write for that cycle and compares both outputs on every clock. Acknowledge and read-data bits are driven three clocks after an SCL fall, and the bench samples them in the middle of the following SCL high phase, well past that point. Any change of sda_pull while SCL is high is also flagged.

// File: rtl/cfg_blk_pkg.sv
// Package: shared types and per-byte constants for the configuration slave.
// Assumes a bank of at least eight bytes; byte 6 is the control byte and
// byte 7 holds the low enables.
package cfg_blk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,    // not addressed, SDA released
        PH_RX,      // shifting in a byte from the master
        PH_RXACK,   // slave holds SDA low for the acknowledge
        PH_TX,      // shifting out a byte to the master
        PH_TXACK,   // waiting for the master acknowledge bit
        PH_TXWAIT   // master acknowledged, next byte loads on SCL fall
    } phase_t;

    localparam int CTRL_IDX   = 6;
    localparam int LOEN_IDX   = 7;
    localparam int BOOST_BIT  = 5;
    localparam int PAIR_CNT   = 12;

    // Writable bits of a bank byte; byte 6 keeps bits 7, 6 and 4 fixed.
    function automatic logic [7:0] byte_wmask(int idx);
        return (idx == CTRL_IDX) ? 8'h2F : 8'hFF;
    endfunction

    // Reset value of a bank byte.
    function automatic logic [7:0] byte_rstval(int idx);
        if (idx == CTRL_IDX) return 8'h0F;
        if (idx == LOEN_IDX) return 8'hFF;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfg_line_sync.sv
// Module: brings SCL and SDA into the system clock domain and derives
// SCL edges plus start and stop conditions.
// Assumes the system clock runs many times faster than SCL. The idle bus
// level (both lines high) is the reset value.
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;

    // Synchronizer chains for both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
        end
    end

    assign scl_lvl = scl_sh[STAGES-1];
    assign sda_lvl = sda_sh[STAGES-1];

    // One-cycle history of the synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/cfg_regbank.sv
// Module: configuration byte bank with per-byte write masks and reset
// values, one write port, one combinational read port, and decoded
// control outputs.
// Assumes NUM_BYTES >= 8 so that the control byte and low-enable byte exist.
module cfg_regbank
    import cfg_blk_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int IW = $clog2(NUM_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [IW-1:0]       rd_idx,
    output logic [7:0]          rd_data,
    output logic [PAIR_CNT-1:0] pair_en,
    output logic                drive_boost
);
    logic [7:0] bank_q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam logic [7:0] WM = byte_wmask(g);
        localparam logic [7:0] RV = byte_rstval(g);
        // Store one byte; fixed bits keep their reset value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= RV;
            else if (wr_en && wr_idx == IW'(g))
                bank_q[g] <= (wr_data & WM) | (RV & ~WM);
        end
    end

    // Read port; an index past the bank returns all ones.
    always_comb begin
        if (int'(rd_idx) < NUM_BYTES) rd_data = bank_q[rd_idx];
        else                          rd_data = 8'hFF;
    end

    // Decode of the control outputs.
    always_comb begin
        pair_en     = {bank_q[CTRL_IDX][3:0], bank_q[LOEN_IDX]};
        drive_boost = bank_q[CTRL_IDX][BOOST_BIT];
    end

    // R2: a write to byte 0 is visible in the following cycle.
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == '0 |=> bank_q[0] == $past(wr_data));

    // R7: the reserved bits of the control byte never leave zero.
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bank_q[CTRL_IDX] & 8'hD0) == 8'h00);

endmodule

// File: rtl/cfg_blk_fsm.sv
// Module: protocol engine. Matches the address, acknowledges bytes, skips
// the command and length bytes of a write, and streams the length byte and
// bank bytes on a read.
// Assumes the SCL and SDA inputs are already synchronized and edge-decoded.
// SDA is only pulled or released, and it changes one cycle after a decoded
// SCL fall.
module cfg_blk_fsm
    import cfg_blk_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NUM_BYTES = 8,
    parameter logic [7:0] LEN_VAL   = 8'h09,
    localparam int IW = $clog2(NUM_BYTES),
    localparam int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] rd_idx,
    output logic          sda_pull
);
    phase_t        ph;
    logic [3:0]    bitcnt;
    logic [7:0]    sh;
    logic          is_rd, in_addr;
    logic [CW-1:0] bidx;

    logic          byte_full, addr_hit, wr_ok, rd_ok;
    logic [CW-1:0] data_pos, rd_pos, bidx_nx;
    logic [7:0]    tx_byte;

    // Byte-position decode for both directions.
    always_comb begin
        byte_full = (bitcnt == 4'd8);
        addr_hit  = (sh[7:1] == DEV_ADDR);
        data_pos  = bidx - CW'(2);
        rd_pos    = bidx - CW'(1);
        wr_ok     = !in_addr && (bidx >= CW'(2)) && (data_pos < CW'(NUM_BYTES));
        rd_ok     = rd_pos < CW'(NUM_BYTES);
        bidx_nx   = (bidx == '1) ? bidx : bidx + CW'(1);
        wr_idx    = data_pos[IW-1:0];
        rd_idx    = rd_pos[IW-1:0];
        wr_data   = sh;
        if (bidx == '0)  tx_byte = LEN_VAL;
        else if (rd_ok)  tx_byte = rd_data;
        else             tx_byte = 8'hFF;
    end

    // Bank write strobe at the SCL fall that ends the eighth data bit.
    assign wr_en = (ph == PH_RX) && scl_fall && byte_full && wr_ok
                   && !start_det && !stop_det;

    // Protocol sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            bitcnt   <= '0;
            sh       <= '0;
            is_rd    <= 1'b0;
            in_addr  <= 1'b0;
            bidx     <= '0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            ph       <= PH_RX;
            bitcnt   <= '0;
            in_addr  <= 1'b1;
            is_rd    <= 1'b0;
            bidx     <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            ph       <= PH_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (ph)
                PH_RX: begin
                    if (scl_rise && !byte_full) begin
                        sh     <= {sh[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && byte_full) begin
                        if (in_addr) begin
                            if (addr_hit) begin
                                sda_pull <= 1'b1;
                                is_rd    <= sh[0];
                                ph       <= PH_RXACK;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end else begin
                            sda_pull <= 1'b1;
                            bidx     <= bidx_nx;
                            ph       <= PH_RXACK;
                        end
                    end
                end
                PH_RXACK: begin
                    if (scl_fall) begin
                        in_addr <= 1'b0;
                        if (in_addr && is_rd) begin
                            sh       <= tx_byte;
                            sda_pull <= ~tx_byte[7];
                            bitcnt   <= 4'd1;
                            bidx     <= bidx_nx;
                            ph       <= PH_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            ph       <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (byte_full) begin
                            sda_pull <= 1'b0;
                            ph       <= PH_TXACK;
                        end else begin
                            sda_pull <= ~sh[6];
                            sh       <= {sh[6:0], 1'b0};
                            bitcnt   <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) ph <= sda_lvl ? PH_IDLE : PH_TXWAIT;
                end
                PH_TXWAIT: begin
                    if (scl_fall) begin
                        sh       <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                        bitcnt   <= 4'd1;
                        bidx     <= bidx_nx;
                        ph       <= PH_TX;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R5: when idle the line is always released.
    p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_IDLE |-> !sda_pull);

    // R5: a master NACK ends the transfer in the next cycle.
    p_nack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_TXACK && scl_rise && sda_lvl && !start_det && !stop_det
        |=> ph == PH_IDLE && !sda_pull);

    // R9: SDA moves only while SCL is low, except the abort release.
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) && !$past(start_det) && !$past(stop_det)
        |-> !scl_lvl);

    // R8: a stop returns the engine to idle with SDA released.
    p_stop_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> ph == PH_IDLE && !sda_pull);

    // R2: the bank is never written during a read transfer.
    p_no_wr_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !is_rd);

    // R1: a mismatched address byte gets no acknowledge.
    p_addr_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_RX && in_addr && scl_fall && byte_full && !addr_hit
        && !start_det && !stop_det |=> ph == PH_IDLE && !sda_pull);

endmodule

// File: rtl/cfg_blk_slave.sv
// Module: top of the serial configuration slave. Ties the line
// synchronizer, the protocol engine and the configuration bank together.
// Assumes the pad logic turns sda_pull into an open-drain driver and
// returns the wired bus level on sda_in.
module cfg_blk_slave
    import cfg_blk_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_BYTES   = 8,
    parameter logic [7:0] LEN_VAL     = 8'h09,
    parameter int         SYNC_STAGES = 2,
    localparam int IW = $clog2(NUM_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull,
    output logic [PAIR_CNT-1:0] pair_en,
    output logic                drive_boost
);
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;

    cfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    cfg_blk_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES), .LEN_VAL(LEN_VAL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .sda_pull(sda_pull)
    );

    cfg_regbank #(.NUM_BYTES(NUM_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .pair_en(pair_en), .drive_boost(drive_boost)
    );

endmodule

// File: tb/cfg_blk_slave_test.sv
// Bench: drives the two-wire bus as a master and keeps a behavioural model
// of the bank. Register outputs are compared on every clock; acknowledge
// and read bits are checked at mid-SCL-high.
module cfg_blk_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;       // system clocks per SCL half period
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m, sda_m;
    logic        sda_pull, drive_boost;
    logic [11:0] pair_en;
    wire         sda_line = sda_m & ~sda_pull;

    int          cyc = 0;
    int          n_cmp = 0, n_bad = 0;
    int          last_fall = 0;
    bit          done = 1'b0;
    logic        prev_pull = 1'b0;
    logic [7:0]  mdl [8];
    int          q_due[$], q_idx[$];
    logic [7:0]  q_val[$];

    cfg_blk_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .pair_en(pair_en), .drive_boost(drive_boost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-clock reference model: apply due writes, compare outputs, watch SDA.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                mdl[q_idx[0]] = q_val[0];
                void'(q_due.pop_front());
                void'(q_idx.pop_front());
                void'(q_val.pop_front());
            end
            chk(pair_en == {mdl[6][3:0], mdl[7]}, "R6 pair_en", pair_en, {mdl[6][3:0], mdl[7]});
            chk(drive_boost == mdl[6][5], "R7 drive_boost", drive_boost, mdl[6][5]);
            if (sda_pull !== prev_pull) chk(scl_m == 1'b0, "R9 sda change with SCL high", scl_m, 0);
            prev_pull = sda_pull;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; last_fall = cyc;
        tick(2);
    endtask

    // Sends a byte; widx >= 0 schedules a model write (R2, R3 discard past 7).
    task automatic send_byte(input logic [7:0] v, input int widx, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        if (widx >= 0 && widx < 8) begin
            q_due.push_back(last_fall + 3);
            q_idx.push_back(widx);
            q_val.push_back(widx == 6 ? (v & 8'h2F) : v);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H/2);
        ack = (sda_line == 1'b0);
        tick(H/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        sda_m = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            scl_m = 1'b1; tick(H/2);
            v = {v[6:0], sda_line};
            tick(H/2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic [7:0] v;
        logic [7:0] wvals [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hF5, 8'hA5};
        for (int i = 0; i < 8; i++) mdl[i] = (i == 6) ? 8'h0F : ((i == 7) ? 8'hFF : 8'h00);
        scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(sda_pull == 1'b0, "R10 reset sda_pull", sda_pull, 0);
        chk(pair_en == 12'hFFF, "R6 reset pair_en", pair_en, 12'hFFF);
        chk(drive_boost == 1'b0, "R7 reset drive_boost", drive_boost, 0);

        // Block write of the whole bank plus one extra byte.
        bus_start();
        send_byte(8'hD2, -1, ack); chk(ack, "R1 write address ack", ack, 1);
        send_byte(8'h5A, -1, ack); chk(ack, "R2 command byte ack", ack, 1);
        send_byte(8'h03, -1, ack); chk(ack, "R2 length byte ack", ack, 1);
        for (int i = 0; i < 8; i++) begin
            send_byte(wvals[i], i, ack); chk(ack, "R2 data byte ack", ack, 1);
        end
        send_byte(8'h77, 8, ack); chk(ack, "R3 extra byte ack", ack, 1);
        bus_stop(); tick(4);
        chk(pair_en == 12'h5A5, "R6 pair_en after write", pair_en, 12'h5A5);
        chk(drive_boost == 1'b1, "R7 boost after write", drive_boost, 1);

        // Block read: length, bank, one byte past the bank, then NACK.
        bus_start();
        send_byte(8'hD3, -1, ack); chk(ack, "R1 read address ack", ack, 1);
        recv_byte(v, 1'b1); chk(v == 8'h09, "R4 length byte", v, 8'h09);
        for (int i = 0; i < 8; i++) begin
            recv_byte(v, 1'b1); chk(v == mdl[i], "R4 R7 bank byte", v, mdl[i]);
        end
        recv_byte(v, 1'b0); chk(v == 8'hFF, "R4 past bank", v, 8'hFF);
        tick(4);
        chk(sda_pull == 1'b0, "R5 released after NACK", sda_pull, 0);
        for (int i = 0; i < 9; i++) begin
            tick(H); scl_m = 1'b1; tick(H/2);
            chk(sda_line == 1'b1, "R5 silent after NACK", sda_line, 1);
            tick(H/2); scl_m = 1'b0; tick(2);
        end
        bus_stop();

        // Wrong address: no acknowledge, later matching pattern also ignored.
        bus_start();
        send_byte(8'hA0, -1, ack); chk(!ack, "R1 wrong address nack", ack, 0);
        send_byte(8'hD2, -1, ack); chk(!ack, "R1 ignored until start", ack, 0);
        bus_stop();

        // Abort by stop in the middle of a data byte.
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h99, 0, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop();

        // New frame restarts at byte 0, then a start aborts a partial byte.
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'hAB, 0, ack); chk(ack, "R8 restart write ack", ack, 1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'hD3, -1, ack); chk(ack, "R8 address after restart", ack, 1);
        recv_byte(v, 1'b1); chk(v == 8'h09, "R8 length after restart", v, 8'h09);
        recv_byte(v, 1'b1); chk(v == 8'hAB, "R8 byte 0 restarted", v, 8'hAB);
        recv_byte(v, 1'b0); chk(v == 8'h22, "R8 partial byte not stored", v, 8'h22);
        bus_stop();
        tick(10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule